// File: doc/BRIEF.md
# Receiver Level Invalid Detector

This block turns per-receiver line-level classification into a single active-low status that reports whether any usable serial link is present. For each receiver, external comparators supply two digital flags: one saying the line magnitude exceeds the upper threshold (2.7 V in either polarity, a valid level), and one saying the line sits inside the near-ground band (between -0.3 V and +0.3 V, an invalid level). A line with neither flag is indeterminate. An unplugged cable lets the inputs fall to ground, so every receiver then reports invalid.

The status drops low only after every receiver has been invalid, without a break, for a long persistence window (`LOW_CYCLES`, nominally 60 µs of clock cycles). It returns high after a short confirmation delay (`HIGH_CYCLES`, nominally 1 µs) once any one receiver shows a valid level. While no receiver is valid and at least one is indeterminate, the status holds. The block has no power-mode input and keeps running whatever the rest of the interface is doing. Its output only influences power state if the system wires it to the force controls of a powerdown controller.

Top module: `rx_level_invalid_det`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `link_invalid_n_o` is 0, and the persistence and confirmation counts are cleared.
- R2: Each receiver's flags are classified after `SYNC_STAGES` flops. A set valid flag means valid, whether or not the invalid flag is also set (valid has priority). The invalid flag alone means invalid. Neither flag means indeterminate.
- R3: When all receivers become invalid together and stay so, `link_invalid_n_o` falls on the (`SYNC_STAGES` + `LOW_CYCLES`)-th rising clock edge after the input change, and not before.
- R4: Any receiver leaving the invalid band, into indeterminate or valid, restarts the persistence count. Only an unbroken all-invalid interval of the full length lowers the output.
- R5: When any receiver becomes valid and stays so, `link_invalid_n_o` rises on the (`SYNC_STAGES` + `HIGH_CYCLES`)-th rising edge after the change. A valid level held for fewer than `HIGH_CYCLES` synchronized cycles leaves the output unchanged.
- R6: While no receiver is valid and not all are invalid, `link_invalid_n_o` keeps its previous value, whether that is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_valid_i | input | NUM_RX | Per-receiver flag: magnitude above upper threshold |
| lvl_invalid_i | input | NUM_RX | Per-receiver flag: level inside near-ground band |
| link_invalid_n_o | output | 1 | Low when no valid link level has been present |

## Verification
The main function is driven with all-invalid runs, single-receiver valid levels on each receiver in turn, fully indeterminate lines, mixes of invalid and indeterminate, and both flags set together. Each pattern is applied from the high state and from the low state. This separates a correct hold from a spurious change, and valid priority from invalid priority. Exact-edge checks of the fall and rise, one edge before and on the edge itself, catch an off-by-one in either window. A one-cycle indeterminate break inside an all-invalid run shows whether the persistence count really restarts. A valid pulse shorter than the confirmation delay shows whether short valid levels are filtered out.

// File: rtl/rlid_pkg.sv
package rlid_pkg;

    typedef enum logic [1:0] {
        LVL_INDET   = 2'd0,
        LVL_INVALID = 2'd1,
        LVL_VALID   = 2'd2
    } lvl_class_e;

    // Valid wins over invalid if a comparator reports both.
    function automatic lvl_class_e classify_level(input logic is_valid, input logic is_invalid);
        if (is_valid)
            return LVL_VALID;
        else if (is_invalid)
            return LVL_INVALID;
        else
            return LVL_INDET;
    endfunction

endpackage

// File: rtl/rlid_sync.sv
module rlid_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stage_q[0] <= '0;
        else
            stage_q[0] <= d_i;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[k] <= '0;
            else
                stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rlid_classify.sv
module rlid_classify
    import rlid_pkg::*;
#(
    parameter int NUM_RX = 3
) (
    input  logic [NUM_RX-1:0] valid_s_i,
    input  logic [NUM_RX-1:0] invalid_s_i,
    output logic              any_valid_o,
    output logic              all_invalid_o
);

    lvl_class_e       cls   [NUM_RX];
    logic [NUM_RX-1:0] is_val;
    logic [NUM_RX-1:0] is_inv;

    for (genvar r = 0; r < NUM_RX; r++) begin : g_rx
        assign cls[r]    = classify_level(valid_s_i[r], invalid_s_i[r]);
        assign is_val[r] = (cls[r] == LVL_VALID);
        assign is_inv[r] = (cls[r] == LVL_INVALID);
    end

    assign any_valid_o   = |is_val;
    assign all_invalid_o = &is_inv;

endmodule

// File: rtl/rlid_persist.sv
module rlid_persist #(
    parameter int LOW_CYCLES  = 6000,
    parameter int HIGH_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic any_valid_i,
    input  logic all_invalid_i,
    output logic status_n_o
);

    localparam int LO_W = $clog2(LOW_CYCLES + 1);
    localparam int HI_W = $clog2(HIGH_CYCLES + 1);
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(LOW_CYCLES - 1);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(HIGH_CYCLES - 1);

    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;
    logic            lo_done;
    logic            hi_done;

    assign lo_done = all_invalid_i && (lo_cnt >= LO_LAST);
    assign hi_done = any_valid_i   && (hi_cnt >= HI_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
        end else if (!all_invalid_i) begin
            lo_cnt <= '0;
        end else if (lo_cnt < LO_LAST) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (!any_valid_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HI_LAST) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_n_o <= 1'b0;
        else if (hi_done)
            status_n_o <= 1'b1;
        else if (lo_done)
            status_n_o <= 1'b0;
    end

endmodule

// File: rtl/rx_level_invalid_det.sv
module rx_level_invalid_det #(
    parameter int NUM_RX      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYCLES  = 6000,
    parameter int HIGH_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RX-1:0] lvl_valid_i,
    input  logic [NUM_RX-1:0] lvl_invalid_i,
    output logic              link_invalid_n_o
);

    logic [NUM_RX-1:0] valid_s;
    logic [NUM_RX-1:0] invalid_s;
    logic              any_valid;
    logic              all_invalid;

    rlid_sync #(.WIDTH(2*NUM_RX), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({lvl_valid_i, lvl_invalid_i}),
        .q_o ({valid_s, invalid_s})
    );

    rlid_classify #(.NUM_RX(NUM_RX)) u_classify (
        .valid_s_i     (valid_s),
        .invalid_s_i   (invalid_s),
        .any_valid_o   (any_valid),
        .all_invalid_o (all_invalid)
    );

    rlid_persist #(.LOW_CYCLES(LOW_CYCLES), .HIGH_CYCLES(HIGH_CYCLES)) u_persist (
        .clk           (clk),
        .rst           (rst),
        .any_valid_i   (any_valid),
        .all_invalid_i (all_invalid),
        .status_n_o    (link_invalid_n_o)
    );

endmodule

// File: rtl/rlid_checker.sv
module rlid_checker #(
    parameter int LOW_CYCLES  = 6000,
    parameter int HIGH_CYCLES = 100
) (
    input logic clk,
    input logic rst,
    input logic any_valid,
    input logic all_invalid,
    input logic status_n
);

    localparam int LW = $clog2(LOW_CYCLES + 1);
    localparam int HW = $clog2(HIGH_CYCLES + 1);

    logic [LW-1:0] inv_run;
    logic [HW-1:0] val_run;

    always_ff @(posedge clk) begin
        if (rst || !all_invalid)
            inv_run <= '0;
        else if (inv_run < LW'(LOW_CYCLES))
            inv_run <= inv_run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !any_valid)
            val_run <= '0;
        else if (val_run < HW'(HIGH_CYCLES))
            val_run <= val_run + 1'b1;
    end

    AST_FALL_NEEDS_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(status_n) |-> (inv_run >= LW'(LOW_CYCLES))); // R3

    AST_RISE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(status_n) |-> (val_run >= HW'(HIGH_CYCLES))); // R5

    AST_INDET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!any_valid && !all_invalid) |=> $stable(status_n)); // R6

    AST_BREAK_BLOCKS_FALL: assert property (@(posedge clk) disable iff (rst)
        (!all_invalid && status_n) |=> status_n); // R4

endmodule

bind rx_level_invalid_det rlid_checker #(
    .LOW_CYCLES  (LOW_CYCLES),
    .HIGH_CYCLES (HIGH_CYCLES)
) u_rlid_checker (
    .clk         (clk),
    .rst         (rst),
    .any_valid   (any_valid),
    .all_invalid (all_invalid),
    .status_n    (link_invalid_n_o)
);

// File: tb/test_rx_level_invalid_det.sv
`timescale 1ns/1ps
module test_rx_level_invalid_det;

    localparam int N  = 3;
    localparam int S  = 2;
    localparam int L  = 20;
    localparam int H  = 4;
    localparam int NV = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] vflag = '0;
    logic [N-1:0] iflag = '0;
    logic         stat_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rx_level_invalid_det #(
        .NUM_RX(N), .SYNC_STAGES(S), .LOW_CYCLES(L), .HIGH_CYCLES(H)
    ) i_rx_level_invalid_det (
        .clk              (clk),
        .rst              (rst),
        .lvl_valid_i      (vflag),
        .lvl_invalid_i    (iflag),
        .link_invalid_n_o (stat_n)
    );

    // {valid[2:0], invalid[2:0], cycles[7:0], expected}
    localparam logic [14:0] VEC [NV] = '{
        {3'b000, 3'b111, 8'd30, 1'b0},  // R3 all invalid from reset
        {3'b001, 3'b000, 8'd10, 1'b1},  // R5 rx0 valid
        {3'b000, 3'b000, 8'd40, 1'b1},  // R6 all indeterminate, hold high
        {3'b000, 3'b111, 8'd30, 1'b0},  // R3 fall
        {3'b000, 3'b011, 8'd40, 1'b0},  // R6 mixed, hold low
        {3'b010, 3'b010, 8'd10, 1'b1},  // R2 both flags on rx1 -> valid
        {3'b000, 3'b111, 8'd10, 1'b1},  // R3 too short
        {3'b000, 3'b110, 8'd3,  1'b1},  // R4 rx0 indeterminate break
        {3'b000, 3'b111, 8'd15, 1'b1},  // R4 count restarted
        {3'b000, 3'b111, 8'd10, 1'b0},  // R4 full run reached
        {3'b100, 3'b011, 8'd2,  1'b0},  // R5 rx2 valid, not yet
        {3'b100, 3'b011, 8'd10, 1'b1},  // R5 rx2 valid confirmed
        {3'b000, 3'b111, 8'd30, 1'b0},  // R3 fall again
        {3'b001, 3'b110, 8'd3,  1'b0},  // R5 short valid pulse filtered
        {3'b000, 3'b111, 8'd10, 1'b0}   // R5 still low after pulse
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: link_invalid_n_o=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] v, input logic [N-1:0] i);
        vflag = v;
        iflag = i;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        check(stat_n, 1'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(stat_n, 1'b0, "R1 after release");

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][14:12], VEC[k][11:9]);
            repeat (int'(VEC[k][8:1])) @(negedge clk);
            check(stat_n, VEC[k][0], $sformatf("R2/R3/R4/R5/R6 vector %0d", k));
        end

        // R3 exact fall edge: start high
        drive(3'b001, 3'b000);
        repeat (10) @(negedge clk);
        check(stat_n, 1'b1, "R5 setup high");
        drive(3'b000, 3'b111);
        repeat (S + L - 1) @(negedge clk);
        check(stat_n, 1'b1, "R3 one edge before fall");
        @(negedge clk);
        check(stat_n, 1'b0, "R3 fall edge");

        // R5 exact rise edge: start low
        drive(3'b010, 3'b000);
        repeat (S + H - 1) @(negedge clk);
        check(stat_n, 1'b0, "R5 one edge before rise");
        @(negedge clk);
        check(stat_n, 1'b1, "R5 rise edge");

        // R1 reset from high state clears output
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(stat_n, 1'b0, "R1 mid-run reset");
        rst = 1'b0;
        drive(3'b000, 3'b000);
        repeat (20) @(negedge clk);
        check(stat_n, 1'b0, "R6 hold low after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule